// File: doc/BRIEF.md
# Paged Address Generation Unit

This block turns a 16-bit logical address into a 19-bit physical address by prefixing it with a 3-bit page number. Memory is split into eight pages of 64K each. Four page registers are kept: a code page, a data page, a stack page and an extra page used only for moves between pages. A 2-bit access kind picks which register supplies the top three address bits. Keeping separate pages for code, data and stack lets each of them live in a different 64K window.

The code, data and stack pages form a 9-bit slice of the processor status word. The extra page stands apart from that word. The block owns all four registers. The surrounding core changes them through a single field-write port, which serves the set-page, page-jump and set-extra-page operations. An interrupt-entry strobe clears the code page. An interrupt-return strobe reloads the three status-word fields from the status word popped off the stack. Saving the status word on interrupt entry is done by the core, which reads the page outputs.

Top module: `paged_agu`

## Requirements
- R1: When `accKind` is 00 (code fetch or branch target), `physAddr` equals {code page, `logAddr`}, combinationally in the same cycle.
- R2: When `accKind` is 01 (data), `physAddr` equals {data page, `logAddr`}.
- R3: When `accKind` is 10 (stack), `physAddr` equals {stack page, `logAddr`}.
- R4: When `accKind` is 11 (inter-page move), `physAddr` equals {extra page, `logAddr`}.
- R5: While `rstN` is low, and after it rises, all four page registers read 0 until the first update.
- R6: With `wrEn` high, the field named by `wrSel` (00 code, 01 data, 10 stack, 11 extra) takes `wrVal[2:0]` at the next rising edge. Bits 15..3 of `wrVal` are ignored, and the other fields keep their values.
- R7: A field write does not change `physAddr` in the cycle in which it is requested. The new page appears in the address only from the following cycle.
- R8: `intEnter` sets the code page to 0 at the next edge. It leaves the data, stack and extra pages alone, and it wins over a code-page write or a restore in the same cycle.
- R9: `intReturn` loads the code, data and stack pages from `retSr` bits 15..13, 12..10 and 9..7 at the next edge. The other bits of `retSr` are ignored. The restore wins over a same-cycle field write to those three fields, but a same-cycle write to the extra page still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| logAddr | input | 16 | Logical address |
| accKind | input | 2 | Access kind: 00 code, 01 data, 10 stack, 11 extra page |
| wrEn | input | 1 | Page field write strobe |
| wrSel | input | 2 | Field to write: 00 code, 01 data, 10 stack, 11 extra |
| wrVal | input | 16 | Write value; only bits 2..0 are used |
| intEnter | input | 1 | Interrupt entry: clear code page |
| intReturn | input | 1 | Interrupt return: restore page fields from `retSr` |
| retSr | input | 16 | Status word popped on interrupt return |
| physAddr | output | 19 | Physical address |
| codePage | output | 3 | Current code page |
| dataPage | output | 3 | Current data page |
| stackPage | output | 3 | Current stack page |
| otherPage | output | 3 | Current extra page |

## Verification
Three updates can land on the same page field in one cycle: a field write, the interrupt-return restore and the interrupt-entry clear. The bench produces every pairing on purpose. It pairs a code-page write with `intEnter`, a data write with `intReturn`, an extra-page write with `intReturn`, and `intEnter` with `intReturn` together. It also fills long random stretches in which all three strobes and the write select vary at once. A behavioural priority model predicts each field. The model is compared with the page outputs and the address on every clock, so a wrong winner shows up as a field mismatch one cycle later.

// File: rtl/pagu_pkg.sv
package pagu_pkg;
  // Field index order: matches wrSel and accKind codes
  localparam int NFIELD = 4;  // code, data, stack, extra
  localparam int NSR    = 3;  // fields that live in the status word

  typedef struct packed {
    logic [NFIELD-1:0] ld;      // plain field load
    logic              restore; // reload status-word fields
    logic              clrCode; // interrupt entry clears code page
  } pageStrobe_t;
endpackage

// File: rtl/pagu_ctrl.sv
module pagu_ctrl
  import pagu_pkg::*;
(
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic       intEnter,
  input  logic       intReturn,
  output pageStrobe_t stb
);
  always_comb begin
    stb = '0;
    if (wrEn) stb.ld[wrSel] = 1'b1;
    // a restore owns the status-word fields this cycle
    if (intReturn) stb.ld[NSR-1:0] = '0;
    stb.restore = intReturn;
    stb.clrCode = intEnter;
  end
endmodule

// File: rtl/pagu_dpath.sv
module pagu_dpath
  import pagu_pkg::*;
#(
  parameter int LOG_W  = 16,
  parameter int PAGE_W = 3,
  parameter int STK_LO = 7,
  localparam int PHYS_W = LOG_W + PAGE_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  pageStrobe_t       stb,
  input  logic [LOG_W-1:0]  wrVal,
  input  logic [LOG_W-1:0]  retSr,
  input  logic [LOG_W-1:0]  logAddr,
  input  logic [1:0]        accKind,
  output logic [PHYS_W-1:0] physAddr,
  output logic [NFIELD-1:0][PAGE_W-1:0] pageVec
);
  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    logic [PAGE_W-1:0] q;
    if (i < NSR) begin : g_sr
      // code sits highest, stack lowest in the status word
      localparam int LO = STK_LO + (NSR - 1 - i) * PAGE_W;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                   q <= '0;
        else if (i == 0 && stb.clrCode) q <= '0;
        else if (stb.restore)        q <= retSr[LO +: PAGE_W];
        else if (stb.ld[i])          q <= wrVal[PAGE_W-1:0];
      end
    end else begin : g_extra
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          q <= '0;
        else if (stb.ld[i]) q <= wrVal[PAGE_W-1:0];
      end
    end
    assign pageVec[i] = q;
  end

  assign physAddr = {pageVec[accKind], logAddr};
endmodule

// File: rtl/paged_agu.sv
module paged_agu
  import pagu_pkg::*;
#(
  parameter int LOG_W  = 16,
  parameter int PAGE_W = 3,
  parameter int STK_LO = 7,
  localparam int PHYS_W = LOG_W + PAGE_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LOG_W-1:0]  logAddr,
  input  logic [1:0]        accKind,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [LOG_W-1:0]  wrVal,
  input  logic              intEnter,
  input  logic              intReturn,
  input  logic [LOG_W-1:0]  retSr,
  output logic [PHYS_W-1:0] physAddr,
  output logic [PAGE_W-1:0] codePage,
  output logic [PAGE_W-1:0] dataPage,
  output logic [PAGE_W-1:0] stackPage,
  output logic [PAGE_W-1:0] otherPage
);
  pageStrobe_t stb;
  logic [NFIELD-1:0][PAGE_W-1:0] pageVec;

  pagu_ctrl u_ctrl (
    .wrEn(wrEn), .wrSel(wrSel), .intEnter(intEnter),
    .intReturn(intReturn), .stb(stb)
  );

  pagu_dpath #(.LOG_W(LOG_W), .PAGE_W(PAGE_W), .STK_LO(STK_LO)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrVal(wrVal), .retSr(retSr),
    .logAddr(logAddr), .accKind(accKind), .physAddr(physAddr),
    .pageVec(pageVec)
  );

  assign codePage  = pageVec[0];
  assign dataPage  = pageVec[1];
  assign stackPage = pageVec[2];
  assign otherPage = pageVec[3];
endmodule

// File: rtl/paged_agu_chk.sv
module paged_agu_chk #(
  parameter int LOG_W  = 16,
  parameter int PAGE_W = 3,
  localparam int PHYS_W = LOG_W + PAGE_W
)(
  input logic              clk,
  input logic              rstN,
  input logic [LOG_W-1:0]  logAddr,
  input logic [1:0]        accKind,
  input logic              wrEn,
  input logic [1:0]        wrSel,
  input logic [LOG_W-1:0]  wrVal,
  input logic              intEnter,
  input logic              intReturn,
  input logic [LOG_W-1:0]  retSr,
  input logic [PHYS_W-1:0] physAddr,
  input logic [PAGE_W-1:0] codePage,
  input logic [PAGE_W-1:0] dataPage,
  input logic [PAGE_W-1:0] stackPage,
  input logic [PAGE_W-1:0] otherPage
);
  // R1
  code_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    accKind == 2'b00 |-> physAddr == {codePage, logAddr});
  // R2
  data_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    accKind == 2'b01 |-> physAddr == {dataPage, logAddr});
  // R3
  stack_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    accKind == 2'b10 |-> physAddr == {stackPage, logAddr});
  // R4
  extra_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    accKind == 2'b11 |-> physAddr == {otherPage, logAddr});
  // R5
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |-> (codePage == '0 && dataPage == '0 && stackPage == '0 && otherPage == '0));
  // R6
  data_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'b01 && !intReturn) |=> dataPage == $past(wrVal[PAGE_W-1:0]));
  // R6
  extra_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'b11) |=> otherPage == $past(wrVal[PAGE_W-1:0]));
  // R8
  int_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    intEnter |=> codePage == '0);
  // R8
  int_enter_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intEnter && !intReturn && !wrEn) |=> $stable(dataPage) && $stable(stackPage));
  // R9
  restore_stack_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReturn |=> stackPage == $past(retSr[9:7]));
endmodule

bind paged_agu paged_agu_chk #(.LOG_W(LOG_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rstN(rstN), .logAddr(logAddr), .accKind(accKind),
  .wrEn(wrEn), .wrSel(wrSel), .wrVal(wrVal), .intEnter(intEnter),
  .intReturn(intReturn), .retSr(retSr), .physAddr(physAddr),
  .codePage(codePage), .dataPage(dataPage), .stackPage(stackPage),
  .otherPage(otherPage)
);

// File: tb/tb_paged_agu.sv
module tb_paged_agu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] logAddr = '0;
  logic [1:0]  accKind = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [15:0] wrVal = '0;
  logic        intEnter = 1'b0;
  logic        intReturn = 1'b0;
  logic [15:0] retSr = '0;
  logic [18:0] physAddr;
  logic [2:0]  codePage, dataPage, stackPage, otherPage;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  int model[4];          // 0 code, 1 data, 2 stack, 3 extra
  string lastTag = "R5";

  always #5 clk = ~clk;

  paged_agu dut (
    .clk(clk), .rstN(rstN), .logAddr(logAddr), .accKind(accKind),
    .wrEn(wrEn), .wrSel(wrSel), .wrVal(wrVal), .intEnter(intEnter),
    .intReturn(intReturn), .retSr(retSr), .physAddr(physAddr),
    .codePage(codePage), .dataPage(dataPage), .stackPage(stackPage),
    .otherPage(otherPage)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare outputs with the model; the address uses current pages (R7)
  task automatic compareAll();
    string aTag;
    case (accKind)
      2'b00: aTag = "R1"; 2'b01: aTag = "R2";
      2'b10: aTag = "R3"; default: aTag = "R4";
    endcase
    check({aTag, "/R7 address"}, int'(physAddr),
          (model[accKind] << 16) | int'(logAddr));
    check({lastTag, " code"},  int'(codePage),  model[0]);
    check({lastTag, " data"},  int'(dataPage),  model[1]);
    check({lastTag, " stack"}, int'(stackPage), model[2]);
    check({lastTag, " extra"}, int'(otherPage), model[3]);
  endtask

  // one clock: drive, compare before the edge, update model after it
  task automatic step(input logic [15:0] la, input logic [1:0] ak,
                      input logic we, input logic [1:0] ws, input logic [15:0] wv,
                      input logic ie, input logic ir, input logic [15:0] rs);
    logAddr = la; accKind = ak; wrEn = we; wrSel = ws; wrVal = wv;
    intEnter = ie; intReturn = ir; retSr = rs;
    #2 compareAll();
    @(posedge clk);
    lastTag = "R7";
    if (ir) begin                          // R9 restore
      model[0] = rs[15:13]; model[1] = rs[12:10]; model[2] = rs[9:7];
      lastTag = "R9";
    end
    if (we && (ws == 2'b11 || !ir)) begin  // R6 write
      model[ws] = wv[2:0];
      if (!ir) lastTag = "R6";
    end
    if (ie) begin                          // R8 clear wins
      model[0] = 0;
      lastTag = "R8";
    end
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 0;
    // R5: garbage strobes under reset
    logAddr = 16'h1234; wrEn = 1'b1; wrSel = 2'b01; wrVal = 16'hffff;
    intReturn = 1'b1; retSr = 16'hffff;
    repeat (3) @(negedge clk);
    #2 compareAll();
    @(negedge clk);
    rstN = 1'b1;
    lastTag = "R5";
    step(16'h0020, 2'b00, 0, 2'b00, 0, 0, 0, 0);
    // R6: each field, upper write bits set
    step(16'hbeef, 2'b01, 1, 2'b01, 16'hfff5, 0, 0, 0);
    step(16'hbeef, 2'b01, 1, 2'b10, 16'h8003, 0, 0, 0);
    step(16'h0100, 2'b10, 1, 2'b11, 16'h7ff6, 0, 0, 0);
    step(16'h0100, 2'b11, 1, 2'b00, 16'h0007, 0, 0, 0);
    // R7: address in write cycle still uses old page
    step(16'h4444, 2'b00, 1, 2'b00, 16'h0002, 0, 0, 0);
    step(16'h4444, 2'b00, 0, 2'b00, 0, 0, 0, 0);
    // R8: interrupt entry beats code write, keeps others
    step(16'h0000, 2'b00, 1, 2'b00, 16'h0005, 1, 0, 0);
    step(16'hfffe, 2'b10, 0, 2'b00, 0, 0, 0, 0);
    // R9: restore, ignored low bits, data write loses
    step(16'h1000, 2'b01, 1, 2'b01, 16'h0007, 0, 1, 16'b101_011_110_1111111);
    step(16'h1000, 2'b01, 0, 2'b00, 0, 0, 0, 0);
    // R9: extra-page write survives a restore
    step(16'h2000, 2'b11, 1, 2'b11, 16'h0001, 0, 1, 16'b010_001_111_0000000);
    step(16'h2000, 2'b11, 0, 2'b00, 0, 0, 0, 0);
    // R8 with R9 together: code cleared, others restored
    step(16'h3000, 2'b00, 0, 2'b00, 0, 1, 1, 16'b111_110_101_0101010);
    step(16'h3000, 2'b10, 0, 2'b00, 0, 0, 0, 0);
    // mixed random stretch
    for (int n = 0; n < 600; n++) begin
      step(16'($urandom), 2'($urandom), ($urandom % 3) == 0, 2'($urandom),
           16'($urandom), ($urandom % 9) == 0, ($urandom % 7) == 0,
           16'($urandom));
    end
    // R5: reset mid-run clears all fields
    step(16'h0000, 2'b00, 1, 2'b01, 16'h0006, 0, 0, 0);
    rstN = 1'b0;
    for (int i = 0; i < 4; i++) model[i] = 0;
    lastTag = "R5";
    #2 compareAll();
    @(negedge clk);
    rstN = 1'b1;
    step(16'h0abc, 2'b01, 0, 2'b00, 0, 0, 0, 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule